// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a slow clock against a fast reference clock. Software programs a number of slow clock periods to observe. The block then counts how many reference clock cycles pass between the first detected rising edge of the chosen slow clock and the rising edge that closes the last of those periods. Three slow clocks can be measured: the output of the slow clock mux, an internal oscillator divided by 256, and an external 32 kHz crystal. Every slow input is asynchronous to the reference clock. Each input is brought into the reference domain by its own synchronizer and rising-edge detector.

Two run modes exist. While the cycling control is high, measurements repeat back to back without any software action. The cycling control is expected to be high out of reset, which makes continuous mode the default. While it is low, one measurement runs for each 0-to-1 transition of the start control. A ready flag goes high when a measurement completes. The result register keeps its value until the next completion. The result saturates at all ones, and a separate flag reports that the true count did not fit. A programmed count of zero turns the block into a detector that raises ready at the next slow edge.

Top module: `slowclk_cal_counter`

## Requirements
- R1: The result equals the number of reference cycles between the first detected rising edge of the selected slow clock after arming and the N-th rising edge after it, where N is `cycles_i`. For a slow clock of period P reference cycles, the result is N*P.
- R2: `src_sel_i` selects the measured clock as follows: 0 selects the slow mux output, 1 selects the divided oscillator and 2 selects the crystal. Code 3 behaves like code 0.
- R3: While `cycling_i` is 1, measurements repeat without any start action. Ready is set after the first completion, and the result follows each later completion, including changes of source. Start transitions are ignored in this mode.
- R4: While `cycling_i` is 0, a measurement begins only on a 0-to-1 transition of `start_i`. Holding `start_i` high starts nothing. After completion the block stays idle and the result holds its value.
- R5: In one-shot mode, a start transition clears ready. The cleared flag is visible in the cycle after the one in which the transition is sampled, and ready is set again when the measurement completes.
- R6: With `cycles_i` equal to 0, ready is set at the first detected slow edge after arming, within one slow period plus synchronizer latency. The result is 0 and the overflow flag is 0.
- R7: When the count would exceed the largest value of the result width, the result holds all ones and `overflow_o` is 1. A count that fits leaves `overflow_o` at 0.
- R8: During and after reset, before any completion, `ready_o`, `result_o` and `overflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock that drives all logic |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| slow_mux_i | input | 1 | Slow clock from the slow clock mux (asynchronous) |
| slow_osc_div_i | input | 1 | Internal oscillator divided by 256 (asynchronous) |
| slow_xtal_i | input | 1 | External 32 kHz crystal clock (asynchronous) |
| src_sel_i | input | 2 | Source select: 0 mux, 1 divided oscillator, 2 crystal, 3 same as 0 |
| cycles_i | input | CYC_W (15) | Number of slow periods to measure, 0 to 32766 |
| cycling_i | input | 1 | 1 = continuous mode, 0 = one-shot mode |
| start_i | input | 1 | One-shot start; acts on its rising transition |
| ready_o | output | 1 | Measurement complete flag |
| result_o | output | RES_W (32) | Reference cycle count, saturating |
| overflow_o | output | 1 | The last completed count did not fit in result_o |

## Verification
The slow clocks are toggled on the reference clock at half periods of 5, 7 and 11 cycles. Each of them therefore has a known exact period, and a result of N*P identifies both the selected source and the window length. The bench runs continuous mode first and then a source change during cycling, which shows that measurements repeat. One-shot runs then use several counts, a held start level, a re-toggled start, count zero and select code 3. These separate edge-triggered from level-triggered starting and show the detector behaviour at count zero. A second instance with a 6-bit result tries counts of 60 and 100. This separates a count that fits from one that saturates and sets the overflow flag.

// File: rtl/scc_pkg.sv
package scc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARM   = 2'd1,
      ST_COUNT = 2'd2
   } scc_state_e;

   localparam int          SCC_NUM_SRC   = 3;
   localparam logic [1:0]  SRC_MUX       = 2'd0;
   localparam logic [1:0]  SRC_OSC_DIV   = 2'd1;
   localparam logic [1:0]  SRC_XTAL      = 2'd2;

endpackage

// File: rtl/scc_sync_edge.sv
module scc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], async_i};
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

   AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R1

endmodule

// File: rtl/scc_edge_select.sv
module scc_edge_select #(
   parameter int NUM_SRC = 3
) (
   input  logic [NUM_SRC-1:0] rise_i,
   input  logic [1:0]         sel_i,
   output logic               rise_o
);
   import scc_pkg::*;

   always_comb begin
      case (sel_i)
         SRC_OSC_DIV: rise_o = rise_i[1];
         SRC_XTAL:    rise_o = rise_i[2];
         default:     rise_o = rise_i[0];
      endcase
   end

endmodule

// File: rtl/scc_sat_counter.sv
module scc_sat_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         en_i,
   output logic [W-1:0] next_o,
   output logic         ovf_next_o
);

   logic [W-1:0] cnt_q;
   logic         sticky_q;
   logic         at_max;

   assign at_max     = &cnt_q;
   assign next_o     = at_max ? cnt_q : cnt_q + W'(1);
   assign ovf_next_o = sticky_q | at_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sticky_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q    <= '0;
         sticky_q <= 1'b0;
      end else if (en_i) begin
         cnt_q    <= next_o;
         sticky_q <= sticky_q | at_max;
      end
   end

   AST_SAT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !clr_i && at_max) |=> ((&next_o) && ovf_next_o)); // R7

endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl #(
   parameter int RES_W = 32,
   parameter int CYC_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cycling_i,
   input  logic [CYC_W-1:0] cycles_i,
   input  logic             edge_i,
   input  logic [RES_W-1:0] cnt_next_i,
   input  logic             cnt_ovf_i,
   output logic             cnt_clr_o,
   output logic             cnt_en_o,
   output logic             ready_o,
   output logic [RES_W-1:0] result_o,
   output logic             overflow_o
);
   import scc_pkg::*;

   scc_state_e       state_q;
   logic             start_q;
   logic [CYC_W-1:0] left_q;
   logic             abort;
   logic             last_edge;
   logic             zero_req;
   scc_state_e       after_done;

   assign abort      = start_i && !start_q && !cycling_i;
   assign last_edge  = edge_i && (left_q == CYC_W'(1));
   assign zero_req   = (cycles_i == '0);
   assign after_done = cycling_i ? ST_ARM : ST_IDLE;

   assign cnt_clr_o = !abort && (state_q == ST_ARM) && edge_i && !zero_req;
   assign cnt_en_o  = !abort && (state_q == ST_COUNT) && !last_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         start_q    <= 1'b0;
         left_q     <= '0;
         ready_o    <= 1'b0;
         result_o   <= '0;
         overflow_o <= 1'b0;
      end else begin
         start_q <= start_i;
         if (abort) begin
            ready_o <= 1'b0;
            state_q <= ST_ARM;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (cycling_i) state_q <= ST_ARM;
               end
               ST_ARM: begin
                  if (edge_i) begin
                     if (zero_req) begin
                        ready_o    <= 1'b1;
                        result_o   <= '0;
                        overflow_o <= 1'b0;
                        state_q    <= after_done;
                     end else begin
                        left_q  <= cycles_i;
                        state_q <= ST_COUNT;
                     end
                  end
               end
               ST_COUNT: begin
                  if (last_edge) begin
                     ready_o    <= 1'b1;
                     result_o   <= cnt_next_i;
                     overflow_o <= cnt_ovf_i;
                     state_q    <= after_done;
                  end else if (edge_i) begin
                     left_q <= left_q - CYC_W'(1);
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !start_q && !cycling_i) |=> !ready_o); // R5

   AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARM && edge_i && zero_req && !abort) |=> (ready_o && result_o == '0)); // R6

   AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_o) |-> ready_o); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> (&result_o)); // R7

endmodule

// File: rtl/slowclk_cal_counter.sv
module slowclk_cal_counter #(
   parameter int RES_W       = 32,
   parameter int CYC_W       = 15,
   parameter int MAX_CYC     = 32766,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             slow_mux_i,
   input  logic             slow_osc_div_i,
   input  logic             slow_xtal_i,
   input  logic [1:0]       src_sel_i,
   input  logic [CYC_W-1:0] cycles_i,
   input  logic             cycling_i,
   input  logic             start_i,
   output logic             ready_o,
   output logic [RES_W-1:0] result_o,
   output logic             overflow_o
);
   import scc_pkg::*;

   localparam int NUM_SRC = SCC_NUM_SRC;

   if (RES_W < 4 || RES_W > 64) begin : g_bad_res_w
      $error("RES_W must lie between 4 and 64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MAX_CYC > (1 << CYC_W) - 1) begin : g_bad_cyc
      $error("MAX_CYC does not fit in CYC_W bits");
   end

   logic [NUM_SRC-1:0] slow_vec;
   logic [NUM_SRC-1:0] rise_vec;
   logic               sel_rise;
   logic               cnt_clr;
   logic               cnt_en;
   logic [RES_W-1:0]   cnt_next;
   logic               cnt_ovf;

   assign slow_vec = {slow_xtal_i, slow_osc_div_i, slow_mux_i};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      scc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk_ref),
         .rst_n   (rst_n),
         .async_i (slow_vec[s]),
         .rise_o  (rise_vec[s])
      );
   end

   scc_edge_select #(.NUM_SRC(NUM_SRC)) u_sel (
      .rise_i (rise_vec),
      .sel_i  (src_sel_i),
      .rise_o (sel_rise)
   );

   scc_sat_counter #(.W(RES_W)) u_cnt (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .clr_i      (cnt_clr),
      .en_i       (cnt_en),
      .next_o     (cnt_next),
      .ovf_next_o (cnt_ovf)
   );

   scc_ctrl #(.RES_W(RES_W), .CYC_W(CYC_W)) u_ctrl (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .cycling_i  (cycling_i),
      .cycles_i   (cycles_i),
      .edge_i     (sel_rise),
      .cnt_next_i (cnt_next),
      .cnt_ovf_i  (cnt_ovf),
      .cnt_clr_o  (cnt_clr),
      .cnt_en_o   (cnt_en),
      .ready_o    (ready_o),
      .result_o   (result_o),
      .overflow_o (overflow_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_ref)
      !rst_n |=> (!ready_o && result_o == '0 && !overflow_o)); // R8

endmodule

// File: tb/slowclk_cal_counter_tb_top.sv
`timescale 1ns/1ps
module slowclk_cal_counter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  slow = 3'b000;
   logic [1:0]  sel = 2'd0;
   logic [14:0] ncyc = 15'd3;
   logic        cycling = 1'b1;
   logic        start = 1'b0;
   logic        ready;
   logic [31:0] result;
   logic        ovf;

   logic [14:0] o_ncyc = 15'd6;
   logic        o_ready;
   logic [5:0]  o_result;
   logic        o_ovf;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   slowclk_cal_counter dut_i (
      .clk_ref(clk), .rst_n(rst_n),
      .slow_mux_i(slow[0]), .slow_osc_div_i(slow[1]), .slow_xtal_i(slow[2]),
      .src_sel_i(sel), .cycles_i(ncyc), .cycling_i(cycling), .start_i(start),
      .ready_o(ready), .result_o(result), .overflow_o(ovf)
   );

   slowclk_cal_counter #(.RES_W(6)) dut_ovf_i (
      .clk_ref(clk), .rst_n(rst_n),
      .slow_mux_i(slow[0]), .slow_osc_div_i(slow[1]), .slow_xtal_i(slow[2]),
      .src_sel_i(2'd0), .cycles_i(o_ncyc), .cycling_i(1'b1), .start_i(1'b0),
      .ready_o(o_ready), .result_o(o_result), .overflow_o(o_ovf)
   );

   // slow clocks: half periods 5, 7, 11 reference cycles, changed away from the active edge
   int ph [3] = '{0, 0, 0};
   int half [3] = '{5, 7, 11};
   always @(negedge clk) begin
      for (int k = 0; k < 3; k++) begin
         ph[k]++;
         if (ph[k] == half[k]) begin
            ph[k] = 0;
            slow[k] <= ~slow[k];
         end
      end
   end

   // behavioural reference model of the main instance
   int          mst;
   longint      mcnt, mres;
   int          mleft;
   bit          mprev, mrdy, movf;
   bit [2:0]    h1, h2, h3;
   localparam longint MAX32 = 64'hFFFF_FFFF;

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = 0; mcnt = 0; mres = 0; mleft = 0;
         mprev = 0; mrdy = 0; movf = 0; h1 = 0; h2 = 0; h3 = 0;
      end else begin
         int s;
         bit e, rise;
         s = (sel == 2'd3) ? 0 : int'(sel);
         e = h2[s] && !h3[s];
         rise = start && !mprev;
         mprev = start;
         h3 = h2; h2 = h1; h1 = slow;
         if (rise && !cycling) begin
            mrdy = 0; mst = 1;
         end else if (mst == 0) begin
            if (cycling) mst = 1;
         end else if (mst == 1) begin
            if (e) begin
               if (ncyc == 0) begin
                  mrdy = 1; mres = 0; movf = 0; mst = cycling ? 1 : 0;
               end else begin
                  mcnt = 0; mleft = int'(ncyc); mst = 2;
               end
            end
         end else begin
            if (e && mleft == 1) begin
               mres = (mcnt + 1 > MAX32) ? MAX32 : mcnt + 1;
               movf = (mcnt + 1 > MAX32);
               mrdy = 1; mst = cycling ? 1 : 0;
            end else begin
               if (e) mleft--;
               mcnt++;
            end
         end
      end
   end

   // compare with the model on every clock (R1 and all timing)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (ready !== mrdy || result !== mres[31:0] || ovf !== movf) begin
            errors++;
            $display("FAIL R1 model compare at cycle %0d: actual rdy=%0b res=%0d ovf=%0b expected rdy=%0b res=%0d ovf=%0b",
                     cyc, ready, result, ovf, mrdy, mres, movf);
         end
      end
   end

   task automatic summary();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         errors++;
         $display("FAIL watchdog (all R) actual %0d cycles expected completion before 100000", cyc);
         summary();
      end
   end

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ready(int limit, output int waited);
      waited = 0;
      while (!ready && waited < limit) begin
         @(negedge clk);
         waited++;
      end
   endtask

   task automatic kick(string tag);
      @(negedge clk); start = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk);
      chk(tag, longint'(ready), 0);
   endtask

   initial begin
      int w;
      longint held;
      idle(3);
      chk("R8 ready in reset", longint'(ready), 0);
      chk("R8 result in reset", longint'(result), 0);
      chk("R8 overflow in reset", longint'(ovf), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R8 ready after reset", longint'(ready), 0);

      // continuous from reset, source 0, N=3 -> 30
      idle(120);
      chk("R3 continuous ready without start", longint'(ready), 1);
      chk("R1 R3 continuous result src0 N=3", longint'(result), 30);
      // source change while cycling: repeats on its own -> 3*14
      sel = 2'd1;
      idle(160);
      chk("R2 R3 continuous result src1 N=3", longint'(result), 42);
      // start ignored in cycling mode
      @(negedge clk); start = 1'b1;
      @(negedge clk);
      chk("R3 start ignored while cycling", longint'(ready), 1);
      start = 1'b0;

      // leave continuous mode, block goes idle and holds
      cycling = 1'b0;
      idle(150);
      held = longint'(result);
      idle(150);
      chk("R4 idle result holds", longint'(result), held);

      // one-shot, crystal source, N=2 -> 44
      sel = 2'd2; ncyc = 15'd2;
      kick("R5 ready drops after start");
      wait_ready(500, w);
      chk("R5 ready set on completion", longint'(ready), 1);
      chk("R1 R2 one-shot src2 N=2", longint'(result), 44);
      // held start level with new count starts nothing
      ncyc = 15'd5;
      idle(300);
      chk("R4 held start does not restart", longint'(result), 44);
      chk("R4 ready stays after one-shot", longint'(ready), 1);
      kick("R5 ready drops on second start");
      wait_ready(800, w);
      chk("R1 one-shot src2 N=5", longint'(result), 110);

      // count zero: ready at next slow edge
      ncyc = 15'd0;
      kick("R6 ready drops for zero count");
      wait_ready(500, w);
      chk("R6 zero count latency within one slow period", longint'(w <= 22 + 4), 1);
      chk("R6 zero count result", longint'(result), 0);
      chk("R6 zero count overflow", longint'(ovf), 0);

      // select code 3 behaves as code 0
      sel = 2'd3; ncyc = 15'd1;
      kick("R5 ready drops for select 3 run");
      wait_ready(500, w);
      chk("R2 select 3 measures mux source", longint'(result), 10);
      start = 1'b0;

      // narrow result instance: fits, then saturates
      chk("R7 6-bit count 60 fits", longint'(o_result), 60);
      chk("R7 no overflow when it fits", longint'(o_ovf), 0);
      o_ncyc = 15'd10;
      idle(300);
      chk("R7 saturated result", longint'(o_result), 63);
      chk("R7 overflow flag", longint'(o_ovf), 1);

      idle(5);
      summary();
   end

endmodule